// File: doc/BRIEF.md
# Four-Phase Parallel Byte Sender

This block streams a fixed-length block of bytes out of a local buffer to a host over an 8-bit parallel bus. The bus is paced by two wires: a wait line that the block drives and a strobe line that the host drives. After a start request, the block reads each byte through a synchronous read port that has one cycle of latency. It places the byte on the bus and then runs a full four-phase exchange with the host before it moves to the next address.

For every byte, the block pulls wait low and waits until it sees the strobe low. One cycle later it raises wait again, then holds until the strobe has returned high. The strobe comes from another clock domain, so it is synchronized before any decision is taken on it. When the last byte has been acknowledged, a one-cycle done pulse hands control back so that the buffer can be refilled and another pass started.

Top module: `byte_port_sender`

## Requirements
- R1: A transfer sends exactly BYTES (default 128) bytes. They are read from buffer addresses 0, 1, 2 and so on upward, and the read address output always shows the index of the byte in progress.
- R2: The byte on the bus is the value the read port returned one cycle after its address was presented. It is driven one cycle before wait falls and stays unchanged until the strobe has been seen high again.
- R3: Once wait is driven low, it stays low at least until the synchronized strobe is seen low.
- R4: Wait is driven high exactly one cycle after the cycle in which the strobe was seen low.
- R5: The strobe passes through a two-flop synchronizer. A change on the strobe pin is acted on at the third rising edge after it is applied.
- R6: The block moves to the next byte only after the synchronized strobe is seen high with wait high.
- R7: Done is high for exactly one cycle after the last byte completes. Wait is high during that cycle, and wait stays high whenever no transfer is running.
- R8: While reset (active low, asynchronous) is asserted: wait is 1, the bus is 0, done is 0 and the read address is 0.
- R9: A start request during a transfer is ignored. A start request in the cycle in which done is high begins a new transfer at address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to send one block; used only when idle |
| strobe_i | input | 1 | Host strobe, asynchronous, low = byte taken |
| rd_addr_o | output | 7 | Buffer read address |
| rd_data_i | input | 8 | Buffer read data, valid one cycle after the address |
| bus_o | output | 8 | Parallel data bus to the host |
| wait_o | output | 1 | Wait/ready line to the host, idles high |
| done_o | output | 1 | One-cycle pulse when a block has been sent |

## Verification
The done pulse that ends one block and the acceptance of the start request for the next block can fall in the same cycle. The bench provokes this by raising start at the moment it observes done high, so that the request is sampled in the only idle cycle between the two blocks. A behavioural model compares the read address, the bus and wait on every cycle of the second block against the model's expected values, starting from address 0. The bench also pulses start in the middle of a block, and the model expects no change in the address sequence.

// File: rtl/bps_pkg.sv
`timescale 1ns/1ps
package bps_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_LOAD,
        ST_ARM,
        ST_SEEK_LO,
        ST_PAUSE,
        ST_SEEK_HI
    } bps_state_e;
endpackage

// File: rtl/bps_sync.sv
`timescale 1ns/1ps
module bps_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b1;
                    else        chain_q[g] <= async_i;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b1;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/bps_ctrl.sv
`timescale 1ns/1ps
module bps_ctrl
    import bps_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int BYTES  = 128,
    localparam int ADDR_W = $clog2(BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              strobe_s_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic [DATA_W-1:0] bus_o,
    output logic              wait_o,
    output logic              done_o
);
    localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(BYTES - 1);

    typedef struct packed {
        bps_state_e        state;
        logic [ADDR_W-1:0] idx;
        logic [DATA_W-1:0] bus;
        logic              waitl;
        logic              done;
    } ctrl_t;

    ctrl_t reg_d, reg_q;

    always_comb begin
        reg_d      = reg_q;
        reg_d.done = 1'b0;
        case (reg_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    reg_d.idx   = '0;
                    reg_d.state = ST_FETCH;
                end
            end
            ST_FETCH: reg_d.state = ST_LOAD;
            ST_LOAD: begin
                reg_d.bus   = rd_data_i;
                reg_d.state = ST_ARM;
            end
            ST_ARM: begin
                reg_d.waitl = 1'b0;
                reg_d.state = ST_SEEK_LO;
            end
            ST_SEEK_LO: begin
                if (!strobe_s_i) reg_d.state = ST_PAUSE;
            end
            ST_PAUSE: begin
                reg_d.waitl = 1'b1;
                reg_d.state = ST_SEEK_HI;
            end
            ST_SEEK_HI: begin
                if (strobe_s_i) begin
                    if (reg_q.idx == LAST_IDX) begin
                        reg_d.done  = 1'b1;
                        reg_d.state = ST_IDLE;
                    end else begin
                        reg_d.idx   = reg_q.idx + 1'b1;
                        reg_d.state = ST_FETCH;
                    end
                end
            end
            default: reg_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_q.state <= ST_IDLE;
            reg_q.idx   <= '0;
            reg_q.bus   <= '0;
            reg_q.waitl <= 1'b1;
            reg_q.done  <= 1'b0;
        end else begin
            reg_q <= reg_d;
        end
    end

    assign rd_addr_o = reg_q.idx;
    assign bus_o     = reg_q.bus;
    assign wait_o    = reg_q.waitl;
    assign done_o    = reg_q.done;
endmodule

// File: rtl/byte_port_sender.sv
`timescale 1ns/1ps
module byte_port_sender #(
    parameter int DATA_W      = 8,
    parameter int BYTES       = 128,
    parameter int SYNC_STAGES = 2,
    localparam int ADDR_W     = $clog2(BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              strobe_i,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic [DATA_W-1:0] bus_o,
    output logic              wait_o,
    output logic              done_o
);
    logic strobe_s;

    bps_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (strobe_i),
        .sync_o  (strobe_s)
    );

    bps_ctrl #(.DATA_W(DATA_W), .BYTES(BYTES)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .strobe_s_i (strobe_s),
        .rd_data_i  (rd_data_i),
        .rd_addr_o  (rd_addr_o),
        .bus_o      (bus_o),
        .wait_o     (wait_o),
        .done_o     (done_o)
    );
endmodule

// File: rtl/byte_port_sender_chk.sv
`timescale 1ns/1ps
module byte_port_sender_chk #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] rd_addr_o,
    input logic [DATA_W-1:0] bus_o,
    input logic              wait_o,
    input logic              done_o
);
    p_bus_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wait_o |-> $stable(bus_o));

    p_addr_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !wait_o |-> $stable(rd_addr_o));

    p_wait_min_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wait_o) |=> !wait_o);

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_wait_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> wait_o);
endmodule

bind byte_port_sender byte_port_sender_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_addr_o (rd_addr_o),
    .bus_o     (bus_o),
    .wait_o    (wait_o),
    .done_o    (done_o)
);

// File: tb/byte_port_sender_test.sv
`timescale 1ns/1ps
module byte_port_sender_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       strobe = 1'b1;
    logic [6:0] rd_addr;
    logic [7:0] rd_data = 8'h00;
    logic [7:0] bus;
    logic       wait_l;
    logic       done;

    int vectors = 0;
    int errors = 0;
    int cycles = 0;
    int dones = 0;
    int host_max = 3;

    always #2.5 clk = ~clk;

    byte_port_sender uut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .strobe_i(strobe),
        .rd_addr_o(rd_addr), .rd_data_i(rd_data), .bus_o(bus),
        .wait_o(wait_l), .done_o(done)
    );

    function automatic logic [7:0] pattern(input int a);
        return 8'((a * 37 + 5) & 255);
    endfunction

    // buffer with one cycle of read latency
    always @(posedge clk) rd_data <= pattern(int'(rd_addr));

    // behavioural reference: phases of one byte exchange
    int s1 = 1, s2 = 1, phase = 0, idx = 0;
    int e_wait = 1, e_bus = 0, e_done = 0;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1 = 1; s2 = 1; phase = 0; idx = 0;
            e_wait = 1; e_bus = 0; e_done = 0;
        end else begin
            int seen;
            seen = s2;
            e_done = 0;
            case (phase)
                0: if (start) begin phase = 1; idx = 0; end
                1: phase = 2;
                2: begin e_bus = pattern(idx); phase = 3; end
                3: begin e_wait = 0; phase = 4; end
                4: if (seen == 0) phase = 5;
                5: begin e_wait = 1; phase = 6; end
                default: if (seen == 1) begin
                    if (idx == 127) begin phase = 0; e_done = 1; end
                    else begin idx = idx + 1; phase = 1; end
                end
            endcase
            s2 = s1;
            s1 = int'(strobe);
        end
    end

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // compare on every cycle, away from the active edge
    always @(negedge clk) begin
        cycles++;
        if (done) dones++;
        check("R1 rd_addr", int'(rd_addr), idx);
        check("R2 bus", int'(bus), e_bus);
        check("R3/R4/R5/R6 wait", int'(wait_l), e_wait);
        check("R7 done", int'(done), e_done);
    end

    // host: four-phase responder with random delays
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && !wait_l) begin
                repeat ($urandom_range(host_max)) @(negedge clk);
                strobe = 1'b0;
                while (!wait_l) @(negedge clk);
                repeat ($urandom_range(host_max)) @(negedge clk);
                strobe = 1'b1;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R8: reset values while reset is held
        check("R8 wait in reset", int'(wait_l), 1);
        check("R8 bus in reset", int'(bus), 0);
        check("R8 done in reset", int'(done), 0);
        check("R8 addr in reset", int'(rd_addr), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // block 1, slow host
        start = 1'b1; @(negedge clk); start = 1'b0;
        repeat (300) @(negedge clk);
        // R9: start in mid-block is ignored (model keeps counting)
        start = 1'b1; @(negedge clk); start = 1'b0;
        while (!done) @(negedge clk);

        // R9: start during the done cycle begins block 2, fast host
        host_max = 0;
        start = 1'b1; @(negedge clk); start = 1'b0;
        check("R9 restart at address 0", int'(rd_addr), 0);
        while (!done) @(negedge clk);

        // block 3, very slow host
        host_max = 8;
        repeat (5) @(negedge clk);
        start = 1'b1; @(negedge clk); start = 1'b0;
        while (!done) @(negedge clk);
        repeat (5) @(negedge clk);

        // R1/R7: one done per block of 128 bytes, wait idles high
        check("R7 done count", dones, 3);
        check("R7 idle wait high", int'(wait_l), 1);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule